// File: doc/BRIEF.md
# Command Stream Packet Parser

The parser sits at the front of a command processor and takes a stream of 32-bit command words over a valid/ready handshake, one word per clock. Each packet opens with a header word. The parser sorts the header into one of five packet kinds. It then consumes the payload words that the header announces. Register-write packets become a sequence of register writes on the write port. Each payload word goes to the next register index, starting from the index held in the header. Opcode packets first produce an announcement on the opcode port, carrying the opcode and the payload count. After that, each payload word is forwarded with its zero-based position in the packet.

The two newer header formats protect their count, register-index and opcode fields with parity bits. The two older formats carry no protection, and they encode the payload count minus one. The newer formats encode the raw count. A header with a parity mismatch, or with an unknown type code, raises a one-cycle error pulse. A damaged packet is swallowed whole and produces no writes.

The control is a four-state machine. HEAD waits for a header. REGW streams register writes. OPDATA streams opcode payload words. SKIP discards the payload of a rejected packet. From HEAD, a register-write header with payload goes to REGW. An opcode header with payload goes to OPDATA. A parity-failed header with a nonzero count goes to SKIP. The no-op header, an unknown code, and every newer header with zero count all stay in HEAD. REGW, OPDATA and SKIP each return to HEAD when they accept their last payload word.

Top module: `cspkt_parser`

## Requirements
- R1: While rst_n is low, in_ready is 0 and wr_valid, op_valid and hdr_err are 0. After reset is released, in_ready goes to 1.
- R2: The packet type is decoded from header bits 31:28. Values 0x0-0x3 are an older register write, 0x8-0xB are a no-op, 0xC-0xF are an older opcode packet, 0x4 is a newer register write and 0x7 is a newer opcode packet. The values 0x5 and 0x6 pulse hdr_err for one cycle, the word is dropped with no other output, and the next word is treated as a header.
- R3: An older register-write header holds the register index in bits 14:0 and the count minus one in bits 29:16. Its N payload words are written to indices base, base+1, …, base+N-1. The index is 18 bits wide and wraps modulo 2^18.
- R4: A newer register-write header holds the count in bits 6:0, the parity of the count in bit 7, an 18-bit register index in bits 25:8 and the parity of the index in bit 27. A count of up to 127 produces that many consecutive writes.
- R5: An older opcode header holds the opcode in bits 15:8 and the count minus one in bits 29:16. It produces one announcement (op_hdr=1, op_code, op_data = payload count). Then each payload word appears with op_hdr=0, the same op_code, and op_pos counting 0, 1, 2, ….
- R6: A newer opcode header holds the count in bits 14:0, the parity of the count in bit 15, a 7-bit opcode in bits 22:16 and the parity of the opcode in bit 23. It is announced and forwarded as in R5.
- R7: Each parity bit gives odd weight to its field plus that bit. Any mismatch pulses hdr_err. The following payload words, in the number given by the raw count field, are then consumed with no write and no opcode output.
- R8: A no-op header is a single word with no payload and no output. The next word is a header.
- R9: A newer header with count 0 consumes no payload. A newer register write with count 0 produces no output. A newer opcode header with count 0 still produces its announcement, with op_data = 0.
- R10: Every output event appears in the clock cycle after the word that caused it is accepted. At most one of wr_valid, op_valid and hdr_err is high in any cycle.
- R11: Cycles with in_valid low produce no output and leave the progress of a packet unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser accepts a word this cycle |
| wr_valid | output | 1 | Register write strobe |
| wr_index | output | 18 | Register index of the write |
| wr_data | output | 32 | Register write value |
| op_valid | output | 1 | Opcode port strobe |
| op_hdr | output | 1 | 1 = opcode announcement, 0 = payload word |
| op_code | output | 8 | Opcode of the current packet |
| op_pos | output | 15 | Payload position, 0-based |
| op_data | output | 32 | Payload word, or the payload count on an announcement |
| hdr_err | output | 1 | One-cycle pulse for a bad or unknown header |

## Verification
The paths that can meet at one clock edge are the end of one packet and the decode of the next header. Back-to-back traffic provokes this. A zero-count newer header is followed directly by another header. The last payload word of a rejected packet is followed at once by a good header. A parity error is followed by a new packet with no idle cycle between them. The scoreboard judges these cases by exact order: the pulse or the announcement must land in the cycle after its own word, followed by the next packet's first output and nothing else, and no write may leak from the discarded payload.

// File: rtl/cspkt_pkg.sv
package cspkt_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 18;
    localparam int CNT_W  = 15;
    localparam int OPC_W  = 8;

    typedef enum logic [2:0] {
        PK_REG_OLD,
        PK_NOP,
        PK_OP_OLD,
        PK_REG_NEW,
        PK_OP_NEW,
        PK_BAD
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_HEAD,
        ST_REGW,
        ST_OPDATA,
        ST_SKIP
    } pstate_e;
endpackage

// File: rtl/cspkt_parity.sv
module cspkt_parity #(
    parameter int W = 7
) (
    input  logic [W-1:0] val,
    output logic         pbit
);
    localparam int          NIB = (W + 3) / 4;
    localparam logic [15:0] LUT = 16'h9669;

    logic [4*NIB-1:0] ext;
    logic [3:0]       fold;

    always_comb begin
        ext         = '0;
        ext[W-1:0]  = val;
        fold        = '0;
        for (int k = 0; k < NIB; k++) begin
            fold = fold ^ ext[4*k +: 4];
        end
    end

    assign pbit = LUT[fold];
endmodule

// File: rtl/cspkt_hdr_decode.sv
module cspkt_hdr_decode
    import cspkt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output pkt_kind_e         kind,
    output logic [CNT_W-1:0]  cnt,
    output logic [IDX_W-1:0]  idx,
    output logic [OPC_W-1:0]  opc,
    output logic              par_ok
);
    logic p_cnt7, p_idx, p_cnt15, p_opc;

    cspkt_parity #(.W(7))     u_p_cnt7  (.val(word[6:0]),   .pbit(p_cnt7));
    cspkt_parity #(.W(IDX_W)) u_p_idx   (.val(word[25:8]),  .pbit(p_idx));
    cspkt_parity #(.W(CNT_W)) u_p_cnt15 (.val(word[14:0]),  .pbit(p_cnt15));
    cspkt_parity #(.W(7))     u_p_opc   (.val(word[22:16]), .pbit(p_opc));

    always_comb begin
        kind   = PK_BAD;
        cnt    = '0;
        idx    = '0;
        opc    = '0;
        par_ok = 1'b1;
        unique case (word[31:30])
            2'b00: begin
                kind = PK_REG_OLD;
                idx  = {{(IDX_W-15){1'b0}}, word[14:0]};
                cnt  = {1'b0, word[29:16]} + 15'd1;
            end
            2'b10: kind = PK_NOP;
            2'b11: begin
                kind = PK_OP_OLD;
                opc  = word[15:8];
                cnt  = {1'b0, word[29:16]} + 15'd1;
            end
            2'b01: begin
                if (word[29:28] == 2'b00) begin
                    kind   = PK_REG_NEW;
                    cnt    = {8'd0, word[6:0]};
                    idx    = word[25:8];
                    par_ok = (p_cnt7 == word[7]) && (p_idx == word[27]);
                end else if (word[29:28] == 2'b11) begin
                    kind   = PK_OP_NEW;
                    cnt    = word[14:0];
                    opc    = {1'b0, word[22:16]};
                    par_ok = (p_cnt15 == word[15]) && (p_opc == word[23]);
                end
            end
            default: kind = PK_BAD;
        endcase
    end
endmodule

// File: rtl/cspkt_parser.sv
module cspkt_parser
    import cspkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_index,
    output logic [WORD_W-1:0] wr_data,
    output logic              op_valid,
    output logic              op_hdr,
    output logic [OPC_W-1:0]  op_code,
    output logic [CNT_W-1:0]  op_pos,
    output logic [WORD_W-1:0] op_data,
    output logic              hdr_err
);
    pstate_e          state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic [OPC_W-1:0] opc_q, opc_d;
    logic             rdy_q;

    pkt_kind_e        d_kind;
    logic [CNT_W-1:0] d_cnt;
    logic [IDX_W-1:0] d_idx;
    logic [OPC_W-1:0] d_opc;
    logic             d_par_ok;

    logic acc;
    logic ev_wr, ev_ophdr, ev_oppay, ev_err;

    cspkt_hdr_decode u_dec (
        .word   (in_data),
        .kind   (d_kind),
        .cnt    (d_cnt),
        .idx    (d_idx),
        .opc    (d_opc),
        .par_ok (d_par_ok)
    );

    assign acc      = in_valid && rdy_q;
    assign in_ready = rdy_q;

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        idx_d    = idx_q;
        pos_d    = pos_q;
        opc_d    = opc_q;
        ev_wr    = 1'b0;
        ev_ophdr = 1'b0;
        ev_oppay = 1'b0;
        ev_err   = 1'b0;
        unique case (state_q)
            ST_HEAD: if (acc) begin
                unique case (d_kind)
                    PK_REG_OLD: begin
                        idx_d    = d_idx;
                        remain_d = d_cnt;
                        state_d  = ST_REGW;
                    end
                    PK_NOP: ;
                    PK_OP_OLD: begin
                        ev_ophdr = 1'b1;
                        opc_d    = d_opc;
                        pos_d    = '0;
                        remain_d = d_cnt;
                        state_d  = ST_OPDATA;
                    end
                    PK_REG_NEW: begin
                        if (!d_par_ok) begin
                            ev_err = 1'b1;
                            if (d_cnt != '0) begin
                                remain_d = d_cnt;
                                state_d  = ST_SKIP;
                            end
                        end else if (d_cnt != '0) begin
                            idx_d    = d_idx;
                            remain_d = d_cnt;
                            state_d  = ST_REGW;
                        end
                    end
                    PK_OP_NEW: begin
                        if (!d_par_ok) begin
                            ev_err = 1'b1;
                            if (d_cnt != '0) begin
                                remain_d = d_cnt;
                                state_d  = ST_SKIP;
                            end
                        end else begin
                            ev_ophdr = 1'b1;
                            opc_d    = d_opc;
                            pos_d    = '0;
                            if (d_cnt != '0) begin
                                remain_d = d_cnt;
                                state_d  = ST_OPDATA;
                            end
                        end
                    end
                    default: ev_err = 1'b1;
                endcase
            end
            ST_REGW: if (acc) begin
                ev_wr    = 1'b1;
                idx_d    = idx_q + 1'b1;
                remain_d = remain_q - 1'b1;
                if (remain_q == 15'd1) state_d = ST_HEAD;
            end
            ST_OPDATA: if (acc) begin
                ev_oppay = 1'b1;
                pos_d    = pos_q + 1'b1;
                remain_d = remain_q - 1'b1;
                if (remain_q == 15'd1) state_d = ST_HEAD;
            end
            ST_SKIP: if (acc) begin
                remain_d = remain_q - 1'b1;
                if (remain_q == 15'd1) state_d = ST_HEAD;
            end
            default: state_d = ST_HEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_HEAD;
            remain_q <= '0;
            idx_q    <= '0;
            pos_q    <= '0;
            opc_q    <= '0;
            rdy_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            idx_q    <= idx_d;
            pos_q    <= pos_d;
            opc_q    <= opc_d;
            rdy_q    <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_index <= '0;
            wr_data  <= '0;
            op_valid <= 1'b0;
            op_hdr   <= 1'b0;
            op_code  <= '0;
            op_pos   <= '0;
            op_data  <= '0;
            hdr_err  <= 1'b0;
        end else begin
            wr_valid <= ev_wr;
            op_valid <= ev_ophdr || ev_oppay;
            op_hdr   <= ev_ophdr;
            hdr_err  <= ev_err;
            if (ev_wr) begin
                wr_index <= idx_q;
                wr_data  <= in_data;
            end
            if (ev_ophdr) begin
                op_code <= d_opc;
                op_pos  <= '0;
                op_data <= {{(WORD_W-CNT_W){1'b0}}, d_cnt};
            end else if (ev_oppay) begin
                op_code <= opc_q;
                op_pos  <= pos_q;
                op_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/cspkt_parser_chk.sv
module cspkt_parser_chk
    import cspkt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wr_valid,
    input logic [IDX_W-1:0]  wr_index,
    input logic              op_valid,
    input logic              op_hdr,
    input logic [OPC_W-1:0]  op_code,
    input logic [CNT_W-1:0]  op_pos,
    input logic              hdr_err
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (!in_ready && !wr_valid && !op_valid && !hdr_err));

    p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, op_valid, hdr_err}));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !(wr_valid || op_valid || hdr_err));

    p_consec_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid ##1 wr_valid |-> wr_index == $past(wr_index) + 1'b1);

    p_pos_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_hdr) ##1 (op_valid && !op_hdr)
        |-> (op_pos == $past(op_pos) + 1'b1) && (op_code == $past(op_code)));

    p_first_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_hdr) ##1 (op_valid && !op_hdr)
        |-> (op_pos == '0) && (op_code == $past(op_code)));
endmodule

bind cspkt_parser cspkt_parser_chk u_chk (.*);

// File: tb/sim_cspkt_parser.sv
module sim_cspkt_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic [17:0] wr_index;
    logic [31:0] wr_data;
    logic        op_valid;
    logic        op_hdr;
    logic [7:0]  op_code;
    logic [14:0] op_pos;
    logic [31:0] op_data;
    logic        hdr_err;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    cspkt_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_data(wr_data), .op_valid(op_valid), .op_hdr(op_hdr),
        .op_code(op_code), .op_pos(op_pos), .op_data(op_data), .hdr_err(hdr_err)
    );

    function automatic logic opar(input logic [31:0] v);
        return ~(^v);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic expect_ev(input int k, input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] c, input string req);
        exp_t e;
        e.kind = k; e.a = a; e.b = b; e.c = c; e.req = req;
        sb.push_back(e);
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: kinds 1 write, 2 announcement, 3 opcode payload, 4 error
    always @(negedge clk) begin
        if (rst_n && (wr_valid || op_valid || hdr_err)) begin
            int   k;
            exp_t e;
            k = wr_valid ? 1 : (op_valid ? (op_hdr ? 2 : 3) : 4);
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected event kind", k, 0);
            end else begin
                e = sb.pop_front();
                check(k == e.kind, e.req, "event kind", k, e.kind);
                if (k == e.kind) begin
                    if (k == 1) begin
                        check(wr_index == e.a[17:0], e.req, "wr_index", {14'd0, wr_index}, e.a);
                        check(wr_data == e.b, e.req, "wr_data", wr_data, e.b);
                    end else if (k == 2 || k == 3) begin
                        check(op_code == e.a[7:0], e.req, "op_code", {24'd0, op_code}, e.a);
                        check(op_data == e.b, e.req, "op_data", op_data, e.b);
                        if (k == 3)
                            check(op_pos == e.c[14:0], e.req, "op_pos", {17'd0, op_pos}, e.c);
                    end
                end
            end
        end
    end

    task automatic reg_old(input logic [14:0] idx, input int n, input logic [31:0] base,
                           input string req);
        send({2'b00, 14'(n - 1), 1'b0, idx});
        for (int i = 0; i < n; i++) begin
            expect_ev(1, 32'(18'(idx) + 18'(i)), base + i, 0, req);
            send(base + i);
        end
    endtask

    task automatic reg_new(input logic [17:0] idx, input int n, input logic [31:0] base,
                           input logic [31:0] flip, input string req);
        logic [31:0] h;
        h = 32'h4000_0000 | 32'(n[6:0]) | (32'(opar(32'(n[6:0]))) << 7)
            | (32'(idx) << 8) | (32'(opar(32'(idx))) << 27);
        h = h ^ flip;
        if (flip != 0) expect_ev(4, 0, 0, 0, "R7");
        send(h);
        for (int i = 0; i < n; i++) begin
            if (flip == 0) expect_ev(1, 32'(idx + 18'(i)), base + i, 0, req);
            send(base + i);
        end
    endtask

    task automatic op_old(input logic [7:0] opc, input int n, input logic [31:0] base,
                          input string req);
        send({2'b11, 14'(n - 1), opc, 8'h00});
        expect_ev(2, 32'(opc), n, 0, req);
        for (int i = 0; i < n; i++) begin
            expect_ev(3, 32'(opc), base + i, i, req);
            send(base + i);
        end
    endtask

    task automatic op_new(input logic [6:0] opc, input int n, input logic [31:0] base,
                          input logic [31:0] flip, input string req);
        logic [31:0] h;
        h = 32'h7000_0000 | 32'(n[14:0]) | (32'(opar(32'(n[14:0]))) << 15)
            | (32'(opc) << 16) | (32'(opar(32'(opc))) << 23);
        h = h ^ flip;
        if (flip != 0) expect_ev(4, 0, 0, 0, "R7");
        else expect_ev(2, 32'(opc), n, 0, req);
        send(h);
        for (int i = 0; i < n; i++) begin
            if (flip == 0) expect_ev(3, 32'(opc), base + i, i, req);
            send(base + i);
        end
    endtask

    initial begin
        #200_000_0;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        check(!in_ready, "R1", "in_ready in reset", in_ready, 0);
        check(!wr_valid && !op_valid && !hdr_err, "R1", "outputs in reset",
              {wr_valid, op_valid, hdr_err}, 0);
        rst_n = 1'b1;
        idle(2);
        check(in_ready, "R1", "in_ready after reset", in_ready, 1);

        reg_old(15'h0123, 3, 32'hA000_0000, "R3");
        reg_new(18'h2ABCD, 2, 32'hB000_0010, 0, "R4");
        reg_new(18'h3FFFF, 2, 32'hB000_0020, 0, "R3");
        reg_new(18'h00100, 127, 32'hC000_0000, 0, "R4");
        op_old(8'hA5, 2, 32'hD000_0000, "R5");
        op_new(7'h55, 3, 32'hE000_0000, 0, "R6");

        // R8 no-op followed directly by a write packet
        send(32'h8123_4567);
        reg_old(15'h0040, 1, 32'h1111_0000, "R8");

        // R9 zero-count newer headers, back to back with next header
        reg_new(18'h00200, 0, 0, 0, "R9");
        op_new(7'h12, 0, 0, 0, "R9");
        reg_old(15'h0050, 1, 32'h2222_0000, "R9");

        // R7 parity faults on each protected field
        reg_new(18'h01000, 2, 32'h3300_0000, 32'h0000_0080, "R7");
        reg_new(18'h01000, 2, 32'h3300_0000, 32'h0800_0000, "R7");
        op_new(7'h33, 1, 32'h3400_0000, 32'h0080_0000, "R7");
        op_new(7'h33, 2, 32'h3400_0000, 32'h0000_8000, "R7");
        reg_old(15'h0060, 2, 32'h3500_0000, "R7");

        // R2 unknown type codes
        expect_ev(4, 0, 0, 0, "R2");
        send(32'h5000_0003);
        expect_ev(4, 0, 0, 0, "R2");
        send(32'h6FFF_FFFF);
        op_old(8'h0F, 1, 32'h4400_0000, "R2");

        // R11 idle gaps in the middle of a packet
        send({2'b00, 14'd2, 1'b0, 15'h0700});
        expect_ev(1, 32'h700, 32'h5500_0000, 0, "R11");
        idle(4);
        send(32'h5500_0000);
        idle(3);
        expect_ev(1, 32'h701, 32'h5500_0001, 0, "R11");
        send(32'h5500_0001);
        idle(2);
        expect_ev(1, 32'h702, 32'h5500_0002, 0, "R11");
        send(32'h5500_0002);

        idle(5);
        check(sb.size() == 0, "R10", "pending expected events", sb.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule